// File: doc/BRIEF.md
# Invalid-Copy Update Push Controller

This block sits beside one cache and decides, for every local store to a block, what message goes out to the other caches. The normal invalidation protocol is kept. On top of it, the block can also send the newly written data so that the other caches can write it into copies they already hold in the invalid state. Those lines stay invalid. They are only a source of values for speculative reads, and the coherent value still arrives through the normal protocol.

A two-bit configuration field selects one of four policies. Policy 0 attaches data to every invalidation. Policy 1 attaches data to an invalidation only when the store is flagged as compressible. Policy 2 pushes data on every Nth store to the same block, counted in a small tagged table. Policy 3 pushes data on every store to a block that another cache holds. The outgoing message is held in a single register until the bus accepts it, and no new store is taken while it waits. Bus arbitration and the compressor sit outside the block, so compressibility arrives as an input flag.

The receive side takes incoming messages. It writes the carried data into the local line only when that line is present and invalid. It never changes any line's coherence state.

Top module: `spec_upd_ctrl`

## Requirements
- R1: After reset, `bc_valid` is 0, `wr_ready` is 1 and `fill_en` is 0, and every per-block store counter reads as zero.
- R2: The message kind is encoded as follows: bit 0 means invalidate and bit 1 means data is carried, so `bc_kind` is 1, 2 or 3 and never 0. A store accepted with `wr_inval` = 1 always produces a message with kind bit 0 set. The message is visible on the cycle after acceptance.
- R3: Under policy 0, every invalidation carries the store data (kind 3). A store with `wr_inval` = 0 produces no message.
- R4: Under policy 1, an invalidation carries data (kind 3) only when `wr_packable` = 1. Otherwise the invalidation is sent without data (kind 1) and `bc_data` is 0. With `wr_inval` = 0 no message is sent.
- R5: Under policy 2, each store to a block advances that block's counter. The store that brings the counter to N pushes data and clears the counter. That message is kind 2, or kind 3 when `wr_inval` = 1. A store that does not reach N sends kind 1 if `wr_inval` = 1 and nothing otherwise.
- R6: Under policy 2, a value of 0 in `cfg_n` acts as 1, so every store pushes.
- R7: The counter table has 16 entries. It is indexed by address bits [3:0] and tagged by the remaining address bits. A store whose tag differs from the one held replaces the entry, and that store counts as the first store. Counters change only under policy 2.
- R8: Under policy 3, a store pushes data when `wr_sharers` = 1 or `wr_inval` = 1. The message is kind 2 without invalidation and kind 3 with it. With neither flag set, no message is sent.
- R9: While `bc_valid` = 1 and `bc_ready` = 0, the message fields hold steady and `wr_ready` is 0. A store is taken only when no message is pending. The policy in force for a store is the value of `cfg_mode` in the cycle that store is accepted.
- R10: A received message with data (`rx_kind` bit 1 set) whose line is present and invalid raises `fill_en` on the next cycle, with that message's address and data.
- R11: A received message is dropped (no `fill_en`) when the line is absent, when the line is valid, or when the message carries no data. The block has no output that changes coherence state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Push policy: 0 all invalidations, 1 compressible only, 2 every N, 3 every store |
| cfg_n | input | 4 | Store count N for policy 2 (0 acts as 1) |
| wr_valid | input | 1 | Local store to a block is offered |
| wr_ready | output | 1 | Store can be taken (no message pending) |
| wr_addr | input | 16 | Block address of the store |
| wr_data | input | 32 | Newly written data |
| wr_inval | input | 1 | Other caches hold valid copies that must be invalidated |
| wr_sharers | input | 1 | Another cache holds a copy of the block in any state |
| wr_packable | input | 1 | Store data is flagged as compressible |
| bc_valid | output | 1 | Outgoing message pending |
| bc_ready | input | 1 | Bus takes the pending message |
| bc_kind | output | 2 | Bit 0 invalidate, bit 1 data carried |
| bc_addr | output | 16 | Message block address |
| bc_data | output | 32 | Message data (0 when none carried) |
| rx_valid | input | 1 | Incoming message from another cache |
| rx_kind | input | 2 | Incoming message kind, same encoding as bc_kind |
| rx_addr | input | 16 | Incoming block address |
| rx_data | input | 32 | Incoming data |
| rx_line_present | input | 1 | Local cache holds a line for rx_addr |
| rx_line_valid | input | 1 | That local line is in a valid state |
| fill_en | output | 1 | Write fill_data into the invalid local line |
| fill_addr | output | 16 | Address to fill |
| fill_data | output | 32 | Data to fill |

## Verification
A counter table entry with a wrong count or tag shows up as a push message that arrives early, late or not at all. It is seen at `bc_valid`/`bc_kind` one cycle after the store that should or should not have reached N. Because the damaged count stays in the table, it also skews every later push for the same block until that entry is replaced. A wrong policy decode shows on the very next message as a wrong kind bit or a data field that should be zero. A faulty hold register shows while `bc_ready` is held low, as a changing message or an early `wr_ready`. A faulty receive filter shows as a `fill_en` pulse one cycle after the incoming message.

// File: rtl/spec_upd_pkg.sv
package spec_upd_pkg;

    typedef enum logic [1:0] {
        POL_INV_ALL    = 2'd0,
        POL_INV_PACKED = 2'd1,
        POL_EVERY_N    = 2'd2,
        POL_EVERY_WR   = 2'd3
    } push_pol_e;

    localparam logic [1:0] KIND_INV     = 2'b01;
    localparam logic [1:0] KIND_UPD     = 2'b10;
    localparam logic [1:0] KIND_INV_UPD = 2'b11;

    typedef struct packed {
        logic send;
        logic inv;
        logic data;
    } push_dec_t;

    function automatic logic [1:0] dec_kind(push_dec_t d);
        return {d.data, d.inv};
    endfunction

endpackage

// File: rtl/upd_cnt_table.sv
module upd_cnt_table #(
    parameter int AW      = 16,
    parameter int ENTRIES = 16,
    parameter int CW      = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic [AW-1:0] addr,
    input  logic [CW-1:0] limit,
    output logic          reach
);
    localparam int IW = $clog2(ENTRIES);
    localparam int TW = AW - IW;

    logic [ENTRIES-1:0] ent_v;
    logic [TW-1:0]      ent_tag [ENTRIES];
    logic [CW-1:0]      ent_cnt [ENTRIES];

    logic [IW-1:0] idx;
    logic [TW-1:0] tag;
    logic          hit;
    logic [CW-1:0] cur;
    logic [CW:0]   nxt;

    always_comb begin
        idx   = addr[IW-1:0];
        tag   = addr[AW-1:IW];
        hit   = ent_v[idx] && (ent_tag[idx] == tag);
        cur   = hit ? ent_cnt[idx] : '0;
        nxt   = {1'b0, cur} + 1'b1;
        reach = (nxt >= {1'b0, limit});
    end

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_v[e]   <= 1'b0;
                ent_tag[e] <= '0;
                ent_cnt[e] <= '0;
            end else if (step && (idx == IW'(e))) begin
                ent_v[e]   <= 1'b1;
                ent_tag[e] <= tag;
                ent_cnt[e] <= reach ? '0 : nxt[CW-1:0];
            end
        end
    end
endmodule

// File: rtl/upd_policy.sv
module upd_policy
    import spec_upd_pkg::*;
(
    input  push_pol_e mode,
    input  logic      inv_need,
    input  logic      sharers,
    input  logic      packable,
    input  logic      n_reach,
    output push_dec_t dec
);
    always_comb begin
        dec.inv = inv_need;
        unique case (mode)
            POL_INV_ALL:    dec.data = inv_need;
            POL_INV_PACKED: dec.data = inv_need & packable;
            POL_EVERY_N:    dec.data = n_reach;
            POL_EVERY_WR:   dec.data = sharers | inv_need;
            default:        dec.data = 1'b0;
        endcase
        dec.send = dec.inv | dec.data;
    end
endmodule

// File: rtl/upd_bcast_reg.sv
module upd_bcast_reg
    import spec_upd_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  push_dec_t     dec,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_data,
    input  logic          out_ready,
    output logic          out_valid,
    output logic [1:0]    out_kind,
    output logic [AW-1:0] out_addr,
    output logic [DW-1:0] out_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_kind  <= '0;
            out_addr  <= '0;
            out_data  <= '0;
        end else if (load && !out_valid) begin
            out_valid <= 1'b1;
            out_kind  <= dec_kind(dec);
            out_addr  <= in_addr;
            out_data  <= dec.data ? in_data : '0;
        end else if (out_valid && out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/upd_rx_fill.sv
module upd_rx_fill #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_valid,
    input  logic [1:0]    rx_kind,
    input  logic [AW-1:0] rx_addr,
    input  logic [DW-1:0] rx_data,
    input  logic          line_present,
    input  logic          line_valid,
    output logic          fill_en,
    output logic [AW-1:0] fill_addr,
    output logic [DW-1:0] fill_data
);
    logic take;
    assign take = rx_valid && rx_kind[1] && line_present && !line_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_en   <= 1'b0;
            fill_addr <= '0;
            fill_data <= '0;
        end else begin
            fill_en <= take;
            if (take) begin
                fill_addr <= rx_addr;
                fill_data <= rx_data;
            end
        end
    end
endmodule

// File: rtl/spec_upd_ctrl.sv
module spec_upd_ctrl
    import spec_upd_pkg::*;
#(
    parameter int AW      = 16,
    parameter int DW      = 32,
    parameter int ENTRIES = 16,
    parameter int NW      = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    cfg_mode,
    input  logic [NW-1:0] cfg_n,
    input  logic          wr_valid,
    output logic          wr_ready,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_inval,
    input  logic          wr_sharers,
    input  logic          wr_packable,
    output logic          bc_valid,
    input  logic          bc_ready,
    output logic [1:0]    bc_kind,
    output logic [AW-1:0] bc_addr,
    output logic [DW-1:0] bc_data,
    input  logic          rx_valid,
    input  logic [1:0]    rx_kind,
    input  logic [AW-1:0] rx_addr,
    input  logic [DW-1:0] rx_data,
    input  logic          rx_line_present,
    input  logic          rx_line_valid,
    output logic          fill_en,
    output logic [AW-1:0] fill_addr,
    output logic [DW-1:0] fill_data
);
    push_pol_e     mode;
    logic          accept;
    logic          n_reach;
    logic [NW-1:0] n_eff;
    push_dec_t     dec;

    assign mode     = push_pol_e'(cfg_mode);
    assign wr_ready = !bc_valid;
    assign accept   = wr_valid && wr_ready;
    assign n_eff    = (cfg_n == '0) ? NW'(1) : cfg_n;

    upd_cnt_table #(.AW(AW), .ENTRIES(ENTRIES), .CW(NW)) u_tbl (
        .clk   (clk),
        .rst   (rst),
        .step  (accept && (mode == POL_EVERY_N)),
        .addr  (wr_addr),
        .limit (n_eff),
        .reach (n_reach)
    );

    upd_policy u_pol (
        .mode     (mode),
        .inv_need (wr_inval),
        .sharers  (wr_sharers),
        .packable (wr_packable),
        .n_reach  (n_reach),
        .dec      (dec)
    );

    upd_bcast_reg #(.AW(AW), .DW(DW)) u_out (
        .clk       (clk),
        .rst       (rst),
        .load      (accept && dec.send),
        .dec       (dec),
        .in_addr   (wr_addr),
        .in_data   (wr_data),
        .out_ready (bc_ready),
        .out_valid (bc_valid),
        .out_kind  (bc_kind),
        .out_addr  (bc_addr),
        .out_data  (bc_data)
    );

    upd_rx_fill #(.AW(AW), .DW(DW)) u_rx (
        .clk          (clk),
        .rst          (rst),
        .rx_valid     (rx_valid),
        .rx_kind      (rx_kind),
        .rx_addr      (rx_addr),
        .rx_data      (rx_data),
        .line_present (rx_line_present),
        .line_valid   (rx_line_valid),
        .fill_en      (fill_en),
        .fill_addr    (fill_addr),
        .fill_data    (fill_data)
    );
endmodule

// File: rtl/spec_upd_ctrl_chk.sv
module spec_upd_ctrl_chk #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    cfg_mode,
    input logic          wr_valid,
    input logic          wr_ready,
    input logic          wr_inval,
    input logic          wr_sharers,
    input logic          wr_packable,
    input logic          bc_valid,
    input logic          bc_ready,
    input logic [1:0]    bc_kind,
    input logic [AW-1:0] bc_addr,
    input logic [DW-1:0] bc_data,
    input logic          rx_valid,
    input logic [1:0]    rx_kind,
    input logic          rx_line_present,
    input logic          rx_line_valid,
    input logic          fill_en
);
    AST_KIND_NONZERO: assert property (@(posedge clk) disable iff (rst)
        bc_valid |-> (bc_kind != 2'b00)); // R2

    AST_INV_SENT: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready && wr_inval) |=> (bc_valid && bc_kind[0])); // R2

    AST_PACKED_ONLY: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready && cfg_mode == 2'd1 && !wr_packable) |=> !(bc_valid && bc_kind[1])); // R4

    AST_EVERYWR_QUIET: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready && cfg_mode == 2'd3 && !wr_sharers && !wr_inval) |=> !bc_valid); // R8

    AST_HOLD_MSG: assert property (@(posedge clk) disable iff (rst)
        (bc_valid && !bc_ready) |=> (bc_valid && $stable(bc_kind) && $stable(bc_addr) && $stable(bc_data))); // R9

    AST_BUSY_NO_TAKE: assert property (@(posedge clk) disable iff (rst)
        bc_valid |-> !wr_ready); // R9

    AST_FILL_INVALID_ONLY: assert property (@(posedge clk) disable iff (rst)
        fill_en |-> $past(rx_valid && rx_kind[1] && rx_line_present && !rx_line_valid)); // R11

    AST_FILL_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_kind[1] && rx_line_present && !rx_line_valid) |=> fill_en); // R10
endmodule

bind spec_upd_ctrl spec_upd_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .cfg_mode        (cfg_mode),
    .wr_valid        (wr_valid),
    .wr_ready        (wr_ready),
    .wr_inval        (wr_inval),
    .wr_sharers      (wr_sharers),
    .wr_packable     (wr_packable),
    .bc_valid        (bc_valid),
    .bc_ready        (bc_ready),
    .bc_kind         (bc_kind),
    .bc_addr         (bc_addr),
    .bc_data         (bc_data),
    .rx_valid        (rx_valid),
    .rx_kind         (rx_kind),
    .rx_line_present (rx_line_present),
    .rx_line_valid   (rx_line_valid),
    .fill_en         (fill_en)
);

// File: tb/spec_upd_ctrl_tb.sv
`timescale 1ns/1ps
module spec_upd_ctrl_tb;
    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    cfg_mode = '0;
    logic [3:0]    cfg_n = 4'd1;
    logic          wr_valid = 1'b0;
    logic          wr_ready;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_inval = 1'b0;
    logic          wr_sharers = 1'b0;
    logic          wr_packable = 1'b0;
    logic          bc_valid;
    logic          bc_ready = 1'b0;
    logic [1:0]    bc_kind;
    logic [AW-1:0] bc_addr;
    logic [DW-1:0] bc_data;
    logic          rx_valid = 1'b0;
    logic [1:0]    rx_kind = '0;
    logic [AW-1:0] rx_addr = '0;
    logic [DW-1:0] rx_data = '0;
    logic          rx_line_present = 1'b0;
    logic          rx_line_valid = 1'b0;
    logic          fill_en;
    logic [AW-1:0] fill_addr;
    logic [DW-1:0] fill_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    spec_upd_ctrl u_dut (.*);

    typedef struct packed {
        logic [1:0]  m;
        logic [3:0]  n;
        logic [15:0] a;
        logic        inv;
        logic        sh;
        logic        pk;
        logic        ev;
        logic [1:0]  ek;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VT [NV] = '{
        '{2'd0, 4'd1, 16'h0010, 1'b1, 1'b1, 1'b0, 1'b1, 2'd3}, // R3
        '{2'd0, 4'd1, 16'h0011, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0}, // R3
        '{2'd1, 4'd1, 16'h0020, 1'b1, 1'b1, 1'b1, 1'b1, 2'd3}, // R4
        '{2'd1, 4'd1, 16'h0021, 1'b1, 1'b1, 1'b0, 1'b1, 2'd1}, // R4
        '{2'd1, 4'd1, 16'h0022, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0}, // R4
        '{2'd3, 4'd1, 16'h0030, 1'b0, 1'b1, 1'b0, 1'b1, 2'd2}, // R8
        '{2'd3, 4'd1, 16'h0031, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0}, // R8
        '{2'd3, 4'd1, 16'h0032, 1'b1, 1'b1, 1'b0, 1'b1, 2'd3}, // R8
        '{2'd2, 4'd3, 16'h0105, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0}, // R5
        '{2'd2, 4'd3, 16'h0105, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0}, // R5
        '{2'd2, 4'd3, 16'h0105, 1'b0, 1'b1, 1'b0, 1'b1, 2'd2}, // R5
        '{2'd2, 4'd3, 16'h0105, 1'b1, 1'b1, 1'b0, 1'b1, 2'd1}, // R5
        '{2'd2, 4'd3, 16'h0105, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0}, // R5
        '{2'd2, 4'd3, 16'h0105, 1'b1, 1'b1, 1'b0, 1'b1, 2'd3}, // R5
        '{2'd2, 4'd3, 16'h0205, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0}, // R7
        '{2'd2, 4'd3, 16'h0105, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0}, // R7
        '{2'd2, 4'd3, 16'h0105, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0}, // R7
        '{2'd2, 4'd3, 16'h0105, 1'b0, 1'b1, 1'b0, 1'b1, 2'd2}, // R7
        '{2'd2, 4'd0, 16'h0307, 1'b0, 1'b1, 1'b0, 1'b1, 2'd2}, // R6
        '{2'd2, 4'd0, 16'h0307, 1'b0, 1'b1, 1'b0, 1'b1, 2'd2}, // R6
        '{2'd2, 4'd1, 16'h0308, 1'b1, 1'b1, 1'b0, 1'b1, 2'd3}, // R6
        '{2'd3, 4'd1, 16'h0105, 1'b0, 1'b1, 1'b0, 1'b1, 2'd2}, // R7
        '{2'd2, 4'd2, 16'h0105, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0}, // R7
        '{2'd2, 4'd2, 16'h0105, 1'b0, 1'b1, 1'b0, 1'b1, 2'd2}  // R7
    };

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "bc_valid after reset", 64'(bc_valid), 64'd0);
        chk("R1", "wr_ready after reset", 64'(wr_ready), 64'd1);
        chk("R1", "fill_en after reset", 64'(fill_en), 64'd0);

        // vector walk: one store per vector, then drain
        for (int i = 0; i < NV; i++) begin
            logic [DW-1:0] d;
            d = 32'hC0DE_0000 | DW'(i);
            cfg_mode    = VT[i].m;
            cfg_n       = VT[i].n;
            wr_addr     = VT[i].a;
            wr_data     = d;
            wr_inval    = VT[i].inv;
            wr_sharers  = VT[i].sh;
            wr_packable = VT[i].pk;
            wr_valid    = 1'b1;
            @(negedge clk);
            wr_valid = 1'b0;
            chk($sformatf("R2/vec%0d", i), "bc_valid", 64'(bc_valid), 64'(VT[i].ev));
            if (VT[i].ev) begin
                chk($sformatf("R2/vec%0d", i), "bc_kind", 64'(bc_kind), 64'(VT[i].ek));
                chk($sformatf("R2/vec%0d", i), "bc_addr", 64'(bc_addr), 64'(VT[i].a));
                chk($sformatf("R4/vec%0d", i), "bc_data", 64'(bc_data),
                    VT[i].ek[1] ? 64'(d) : 64'd0);
            end
            bc_ready = 1'b1;
            @(negedge clk);
            bc_ready = 1'b0;
        end

        // R9: hold while not accepted, mode taken at acceptance
        cfg_mode = 2'd0; wr_addr = 16'h0400; wr_data = 32'h1111_2222;
        wr_inval = 1'b1; wr_sharers = 1'b1; wr_packable = 1'b0; wr_valid = 1'b1;
        @(negedge clk);
        cfg_mode = 2'd1; wr_addr = 16'h0401; wr_data = 32'h3333_4444;
        repeat (3) @(negedge clk);
        chk("R9", "held bc_valid", 64'(bc_valid), 64'd1);
        chk("R9", "wr_ready while pending", 64'(wr_ready), 64'd0);
        chk("R9", "held bc_kind", 64'(bc_kind), 64'd3);
        chk("R9", "held bc_addr", 64'(bc_addr), 64'h0400);
        chk("R9", "held bc_data", 64'(bc_data), 64'h1111_2222);
        bc_ready = 1'b1;
        @(negedge clk);
        bc_ready = 1'b0;
        chk("R9", "drained bc_valid", 64'(bc_valid), 64'd0);
        @(negedge clk);
        wr_valid = 1'b0;
        chk("R9", "next msg valid", 64'(bc_valid), 64'd1);
        chk("R9", "next msg kind uses new mode", 64'(bc_kind), 64'd1);
        chk("R9", "next msg addr", 64'(bc_addr), 64'h0401);
        chk("R9", "next msg data", 64'(bc_data), 64'd0);
        bc_ready = 1'b1;
        @(negedge clk);
        bc_ready = 1'b0;
        wr_inval = 1'b0; wr_sharers = 1'b0;

        // R10: data message into present, invalid line
        rx_valid = 1'b1; rx_kind = 2'd2; rx_addr = 16'h0777; rx_data = 32'hFEED_0001;
        rx_line_present = 1'b1; rx_line_valid = 1'b0;
        @(negedge clk);
        rx_valid = 1'b0;
        chk("R10", "fill_en", 64'(fill_en), 64'd1);
        chk("R10", "fill_addr", 64'(fill_addr), 64'h0777);
        chk("R10", "fill_data", 64'(fill_data), 64'hFEED_0001);
        rx_valid = 1'b1; rx_kind = 2'd3; rx_addr = 16'h0778; rx_data = 32'hFEED_0002;
        @(negedge clk);
        rx_valid = 1'b0;
        chk("R10", "fill_en inv+data", 64'(fill_en), 64'd1);
        chk("R10", "fill_data inv+data", 64'(fill_data), 64'hFEED_0002);

        // R11: drops
        rx_valid = 1'b1; rx_kind = 2'd2; rx_line_present = 1'b1; rx_line_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        chk("R11", "valid line not filled", 64'(fill_en), 64'd0);
        rx_valid = 1'b1; rx_line_present = 1'b0; rx_line_valid = 1'b0;
        @(negedge clk);
        rx_valid = 1'b0;
        chk("R11", "absent line not filled", 64'(fill_en), 64'd0);
        rx_valid = 1'b1; rx_kind = 2'd1; rx_line_present = 1'b1; rx_line_valid = 1'b0;
        @(negedge clk);
        rx_valid = 1'b0;
        chk("R11", "no-data message not filled", 64'(fill_en), 64'd0);
        @(negedge clk);
        chk("R11", "idle fill_en", 64'(fill_en), 64'd0);

        // R1: reset clears counters (block 0x0105 mid-count, then reset)
        cfg_mode = 2'd2; cfg_n = 4'd2; wr_addr = 16'h0105; wr_sharers = 1'b1; wr_inval = 1'b0;
        wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
        chk("R1", "pre-reset first store quiet", 64'(bc_valid), 64'd0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
        chk("R1", "counter cleared by reset", 64'(bc_valid), 64'd0);
        wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
        chk("R1", "push after two stores", 64'(bc_valid), 64'd1);
        chk("R1", "push kind", 64'(bc_kind), 64'd2);
        bc_ready = 1'b1;
        @(negedge clk);
        bc_ready = 1'b0;

        finish_run();
    end
endmodule